// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address by reading two dependent entries from memory. The linear address is cut into three fields: bits 31:22 pick an entry in the page directory, bits 21:12 pick an entry in the page table, and bits 11:0 are the byte offset inside a 4096-byte page. The directory lives at a base address supplied on a root input. The directory entry gives the base of a page table. The table entry gives the page frame, and the frame joined with the offset forms the physical address.

A requester presents a linear address with a valid strobe. The walker takes it only when idle, issues one memory read per level over a request/grant/read-valid port, and then holds a response until it is acknowledged. If either entry has its present bit (bit 0) clear, the walk stops at that level and the response reports a fault together with the linear address that failed.

The control is a six-state machine. IDLE accepts a request and goes to DIR_REQ. DIR_REQ holds the directory read until it is granted, then goes to DIR_WAIT. DIR_WAIT waits for the read data: a present entry leads to TBL_REQ, and an absent one leads to RESP with a fault. TBL_REQ holds the table read until it is granted, then goes to TBL_WAIT. TBL_WAIT waits for the data and goes to RESP with either a translation or a fault. RESP holds the result until it is acknowledged and then returns to IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `rsp_valid`=0, `mem_req`=0.
- R2: The first read goes to address {root_base[31:12], 12'h000} + 4*laddr[31:22]. Bits 11:0 of `root_base` are ignored.
- R3: If the directory entry has bit 0 set, the second read goes to {dir_entry[31:12], 12'h000} + 4*laddr[21:12].
- R4: If both entries have bit 0 set, the response has `rsp_fault`=0 and `rsp_addr`={table_entry[31:12], laddr[11:0]}.
- R5: If the directory entry has bit 0 clear, the response has `rsp_fault`=1 and `rsp_addr`=laddr, and only one memory read is made.
- R6: If the table entry has bit 0 clear, the response has `rsp_fault`=1 and `rsp_addr`=laddr, after exactly two reads.
- R7: `mem_req` stays high with a stable `mem_addr` until `mem_gnt`. Each granted read is followed by waiting for `mem_rvalid`, whatever the grant delay and the read latency.
- R8: `req_ready` is high only while idle. A request presented while a walk or a response is in progress is not taken.
- R9: `rsp_valid`, `rsp_fault` and `rsp_addr` hold steady until `rsp_ack`. The cycle after the acknowledge, `req_ready` is 1 and `rsp_valid` is 0.
- R10: `root_base` is sampled when a request is accepted. Changing it later has no effect on that walk.
- R11: Entry bits 11:1 are ignored when forming both the table address and the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_laddr | input | 32 | Linear address to translate |
| root_base | input | 32 | Page directory base |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_gnt | input | 1 | Memory has taken the read request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (entry) |
| rsp_valid | output | 1 | Response available |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_addr | output | 32 | Physical address, or faulting linear address |
| rsp_ack | input | 1 | Requester takes the response |

## Verification
The acknowledge of a held response and a new request that is already waiting can fall in the same cycle. The bench keeps a second request asserted through a whole walk and raises `rsp_ack` while that request is still pending. The check is that `req_ready` stays low for the whole walk and during the acknowledge cycle. The request must then be taken exactly one cycle later, and its own translation must come back rather than the first one.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_RESP
    } walk_state_t;
endpackage

// File: rtl/pgwalk_addr.sv
// Address arithmetic for the two walk levels and the final physical address.
module pgwalk_addr #(
    parameter int AW       = 32,
    parameter int DIR_W    = 10,
    parameter int TBL_W    = 10,
    parameter int OFF_W    = 12,
    parameter int ENT_LG   = 2
) (
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] root,
    input  logic [AW-1:0] dir_ent,
    input  logic [AW-1:0] tbl_ent,
    output logic [AW-1:0] dir_ea,
    output logic [AW-1:0] tbl_ea,
    output logic [AW-1:0] phys
);
    localparam int TBL_LSB = OFF_W;
    localparam int DIR_LSB = OFF_W + TBL_W;
    localparam int FRM_W   = AW - OFF_W;

    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;
    logic [AW-1:0]    root_base;
    logic [AW-1:0]    tbl_base;

    always_comb begin
        dir_idx   = laddr[DIR_LSB +: DIR_W];
        tbl_idx   = laddr[TBL_LSB +: TBL_W];
        root_base = {root[AW-1 -: FRM_W], {OFF_W{1'b0}}};
        tbl_base  = {dir_ent[AW-1 -: FRM_W], {OFF_W{1'b0}}};
        dir_ea    = root_base + (AW'(dir_idx) << ENT_LG);
        tbl_ea    = tbl_base + (AW'(tbl_idx) << ENT_LG);
        phys      = {tbl_ent[AW-1 -: FRM_W], laddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/pgwalk_ctl.sv
// Walk sequencer: state machine, captured request, captured entry and result.
module pgwalk_ctl
    import pgwalk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_laddr,
    input  logic [AW-1:0] root_base,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_addr,
    input  logic          rsp_ack,
    output logic [AW-1:0] laddr_q,
    output logic [AW-1:0] root_q,
    output logic [AW-1:0] dir_q,
    input  logic [AW-1:0] dir_ea,
    input  logic [AW-1:0] tbl_ea,
    input  logic [AW-1:0] phys
);
    walk_state_t state, state_nx;
    logic        fault_q;
    logic [AW-1:0] res_q;
    logic        present;

    assign present = mem_rdata[0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid)  state_nx = ST_DIR_REQ;
            ST_DIR_REQ:  if (mem_gnt)    state_nx = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rvalid) state_nx = present ? ST_TBL_REQ : ST_RESP;
            ST_TBL_REQ:  if (mem_gnt)    state_nx = ST_TBL_WAIT;
            ST_TBL_WAIT: if (mem_rvalid) state_nx = ST_RESP;
            ST_RESP:     if (rsp_ack)    state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_DIR_REQ: begin mem_req = 1'b1; mem_addr = dir_ea; end
            ST_TBL_REQ: begin mem_req = 1'b1; mem_addr = tbl_ea; end
            ST_RESP:    rsp_valid = 1'b1;
            default:    ;
        endcase
    end
    assign rsp_fault = fault_q;
    assign rsp_addr  = res_q;

    // Captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q <= '0;
            root_q  <= '0;
            dir_q   <= '0;
            res_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                laddr_q <= req_laddr;
                root_q  <= root_base;
            end
            if (state == ST_DIR_WAIT && mem_rvalid) begin
                dir_q <= mem_rdata;
                if (!present) begin
                    fault_q <= 1'b1;
                    res_q   <= laddr_q;
                end
            end
            if (state == ST_TBL_WAIT && mem_rvalid) begin
                fault_q <= !present;
                res_q   <= present ? phys : laddr_q;
            end
        end
    end

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);
    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));
    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ack |=> req_ready && !rsp_valid);
    // R7
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && rsp_valid));
    // R10
    root_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> $stable(root_q));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int AW     = 32,
    parameter int DIR_W  = 10,
    parameter int TBL_W  = 10,
    parameter int OFF_W  = 12,
    parameter int ENT_LG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_laddr,
    input  logic [AW-1:0] root_base,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_addr,
    input  logic          rsp_ack
);
    logic [AW-1:0] laddr_q, root_q, dir_q;
    logic [AW-1:0] dir_ea, tbl_ea, phys;

    pgwalk_addr #(
        .AW(AW), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W), .ENT_LG(ENT_LG)
    ) u_addr (
        .laddr   (laddr_q),
        .root    (root_q),
        .dir_ent (dir_q),
        .tbl_ent (mem_rdata),
        .dir_ea  (dir_ea),
        .tbl_ea  (tbl_ea),
        .phys    (phys)
    );

    pgwalk_ctl #(.AW(AW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_laddr  (req_laddr),
        .root_base  (root_base),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_addr   (rsp_addr),
        .rsp_ack    (rsp_ack),
        .laddr_q    (laddr_q),
        .root_q     (root_q),
        .dir_q      (dir_q),
        .dir_ea     (dir_ea),
        .tbl_ea     (tbl_ea),
        .phys       (phys)
    );
endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic [31:0] root_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_addr;
    logic        rsp_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    int gnt_dly = 0;
    int rd_lat = 0;
    int rd_cnt = 0;
    logic [31:0] rd_log [0:3];
    logic [31:0] bmem [logic [31:0]];

    always #2 clk = ~clk;

    pgwalk_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .root_base(root_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_addr(rsp_addr), .rsp_ack(rsp_ack)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat (gnt_dly) @(negedge clk);
                mem_gnt = 1'b1;
                a = mem_addr;
                if (rd_cnt < 4) rd_log[rd_cnt] = a;
                rd_cnt++;
                @(negedge clk);
                mem_gnt = 1'b0;
                repeat (rd_lat) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata = lookup(a);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata = 32'hDEAD_BEEF;
            end
        end
    end

    // Present at a negedge, accepted at the next posedge, dropped at the negedge after.
    task automatic launch(input logic [31:0] la);
        @(negedge clk);
        rd_cnt = 0;
        req_laddr = la;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        int n = 0;
        while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic finish_rsp(input string tag);
        logic [31:0] a0;
        logic        f0;
        a0 = rsp_addr; f0 = rsp_fault;
        repeat (2) @(negedge clk);
        check({tag, " R9 held addr"}, rsp_addr, a0);
        check({tag, " R9 held fault"}, {31'b0, rsp_fault}, {31'b0, f0});
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        check({tag, " R9 ready after ack"}, {31'b0, req_ready}, 32'd1);
        check({tag, " R9 valid dropped"}, {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 req_ready", {31'b0, req_ready}, 32'd1);
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R1 mem_req", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_translate();
        gnt_dly = 0; rd_lat = 0;
        root_base = 32'h0010_0000;
        launch(32'h0040_3ABC);
        wait_rsp();
        check("R2 dir addr", rd_log[0], 32'h0010_0004);
        check("R3 tbl addr", rd_log[1], 32'h0020_000C);
        check("R4 fault", {31'b0, rsp_fault}, 32'd0);
        check("R4 phys", rsp_addr, 32'h1234_5ABC);
        finish_rsp("translate");
    endtask

    task automatic t_edges();
        gnt_dly = 3; rd_lat = 2;
        root_base = 32'h0010_0123;
        launch(32'hFFFF_FFFF);
        wait_rsp();
        check("R2 dir addr top index, root low ignored", rd_log[0], 32'h0010_0FFC);
        check("R11 tbl addr ignores entry bits", rd_log[1], 32'h0030_0FFC);
        check("R7 two reads with delays", rd_cnt, 2);
        check("R11 phys ignores entry bits", rsp_addr, 32'hABCD_EFFF);
        finish_rsp("edges");
    endtask

    task automatic t_dir_fault();
        gnt_dly = 1; rd_lat = 1;
        root_base = 32'h0010_0000;
        launch(32'h0080_0000);
        wait_rsp();
        check("R5 fault", {31'b0, rsp_fault}, 32'd1);
        check("R5 addr", rsp_addr, 32'h0080_0000);
        check("R5 one read", rd_cnt, 1);
        finish_rsp("dirfault");
    endtask

    task automatic t_tbl_fault();
        gnt_dly = 0; rd_lat = 3;
        root_base = 32'h0010_0000;
        launch(32'h0040_4123);
        wait_rsp();
        check("R6 tbl addr", rd_log[1], 32'h0020_0010);
        check("R6 fault", {31'b0, rsp_fault}, 32'd1);
        check("R6 addr", rsp_addr, 32'h0040_4123);
        check("R6 two reads", rd_cnt, 2);
        finish_rsp("tblfault");
    endtask

    task automatic t_busy();
        int busy_seen = 0;
        gnt_dly = 4; rd_lat = 1;
        root_base = 32'h0010_0000;
        launch(32'h0040_3ABC);
        req_laddr = 32'hFFFF_F001;
        req_valid = 1'b1;
        while (!rsp_valid) begin
            if (req_ready) busy_seen++;
            @(negedge clk);
        end
        check("R8 no ready while walking", busy_seen, 0);
        check("R8 first walk kept", rsp_addr, 32'h1234_5ABC);
        rsp_ack = 1'b1;
        check("R8 not ready in ack cycle", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        rsp_ack = 1'b0;
        check("R9 ready after ack with pending req", {31'b0, req_ready}, 32'd1);
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp();
        check("R8 pending req translated", rsp_addr, 32'hABCD_E001);
        finish_rsp("busy");
    endtask

    task automatic t_root_change();
        gnt_dly = 3; rd_lat = 0;
        root_base = 32'h0010_0000;
        launch(32'h0040_3ABC);
        root_base = 32'h0070_0000;
        wait_rsp();
        check("R10 old root used", rd_log[0], 32'h0010_0004);
        check("R10 result", rsp_addr, 32'h1234_5ABC);
        finish_rsp("root");
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++; tests++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        bmem[32'h0010_0004] = 32'h0020_0001;
        bmem[32'h0020_000C] = 32'h1234_5001;
        bmem[32'h0010_0FFC] = 32'h0030_0FFF;
        bmem[32'h0030_0FFC] = 32'hABCD_E7F3;
        bmem[32'h0010_0008] = 32'h0050_0000;
        bmem[32'h0070_0004] = 32'h0060_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_edges();
        t_dir_fault();
        t_tbl_fault();
        t_busy();
        t_root_change();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule